// File: doc/BRIEF.md
# Burst-Grouping DMA Bus Arbiter

This block shares one memory bus among several DMA channels. Each channel carries a remaining word count, a transfer direction (into memory or out of it) and a priority level. Software writes these through a small configuration port. After that, the arbiter moves each channel's words without any further help. Every cycle in which a channel holds the grant is one word on the bus. The word counter inside each channel stands in for the real datapath.

The arbiter does not hand the bus to whichever channel is ready first. A newly granted channel keeps the bus for a programmable burst of consecutive words. Because of this, read and write traffic alternates less often. A change of bus direction costs two idle cycles. An urgent flag from a peripheral overrides the burst and the priority order at the next word. A channel whose count runs out pulses a completion interrupt. A bus error during a granted word aborts that channel and pulses a separate error interrupt.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and after reset no grant and no interrupt is asserted. At most one grant bit is high in any cycle.
- R2: While every pending channel moves data in the same direction, a word is granted on every cycle until all of them are finished, with no idle bus cycle.
- R3: A channel that wins the bus keeps it for `burst_len_i` consecutive cycles, as long as it stays eligible and no urgent request from another channel appears. A burst length of 0 acts as 1.
- R4: Among the candidates, the channel with the numerically highest priority value wins.
- R5: `grant_dir_o` is 0 for transfers into memory and 1 for transfers out of memory, and it holds the direction of the most recent grant. A grant whose direction differs from the most recent grant is separated from it by exactly two cycles without any grant, when nothing else intervenes.
- R6: Ties in priority are broken round-robin. The search starts at the channel after the one last granted, wrapping from the highest index to 0. After reset, channel 0 comes first.
- R7: If any eligible channel has `urgent_i` set, only urgent channels are candidates. An urgent channel pre-empts a running burst of a non-urgent owner, and it is granted on the cycle after the one in which its flag was sampled.
- R8: When a channel's last word is granted, `done_irq_o` for that channel is high for exactly one cycle, on the cycle after that word. The channel is then idle.
- R9: If `bus_err_i` is high in a cycle in which a channel is granted, that channel is aborted. Its `err_irq_o` bit pulses for one cycle on the next cycle, and it raises no completion pulse.
- R10: A channel is eligible only when its remaining count is nonzero and its `req_i` bit is high. A grant follows one cycle after eligibility is sampled. Loading a count of 0 leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load strobe for one channel's setup |
| cfg_ch_i | input | IDX_W | Channel being loaded |
| cfg_cnt_i | input | CNT_W | Word count to load |
| cfg_dir_i | input | 1 | Direction to load (0 into memory, 1 out of memory) |
| cfg_prio_i | input | PRIO_W | Priority to load, higher wins |
| burst_len_i | input | LEN_W | Words per burst, 0 treated as 1 |
| req_i | input | NCH | Per-channel ready for a word |
| urgent_i | input | NCH | Per-channel urgent flag |
| bus_err_i | input | 1 | Error on the word granted this cycle |
| grant_o | output | NCH | One-hot grant, one word per cycle |
| grant_dir_o | output | 1 | Direction of the most recent grant |
| done_irq_o | output | NCH | Completion pulse per channel |
| err_irq_o | output | NCH | Abort pulse per channel |

## Verification
A request or urgent flag sampled at a rising edge shows up in `grant_o` right after that edge. Completion and error pulses show up on the edge after the word that caused them. A change of direction delays the next grant by two further cycles. The bench updates its behavioural model at the rising edge from the same inputs. It drives stimulus and compares every output a half cycle later, at the falling edge. Each comparison therefore lands on the cycle in which the result is due, and it never lands on the edge at which the result changes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Outcome of one arbitration cycle
    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,   // nobody eligible
        DEC_KEEP = 2'd1,   // current owner continues its burst
        DEC_NEW  = 2'd2,   // a new winner takes the bus
        DEC_HOLD = 2'd3    // winner waits for the bus to turn around
    } arb_dec_e;

endpackage

// File: rtl/dma_arb_chan.sv
module dma_arb_chan #(
    parameter int CNT_W  = 8,
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_cnt_i,
    input  logic              load_dir_i,
    input  logic [PRIO_W-1:0] load_prio_i,
    input  logic              word_i,
    input  logic              bus_err_i,
    output logic              act_nx_o,
    output logic              dir_nx_o,
    output logic [PRIO_W-1:0] prio_nx_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PRIO_W-1:0] prio;
        logic              dir;
        logic              act;
        logic              done;
        logic              err;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        // account for the word moved in this cycle
        if (word_i && s_q.act) begin
            if (bus_err_i) begin
                s_d.act = 1'b0;
                s_d.cnt = '0;
                s_d.err = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.act  = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
        // a new setup replaces the channel's transfer state
        if (load_i) begin
            s_d.cnt  = load_cnt_i;
            s_d.dir  = load_dir_i;
            s_d.prio = load_prio_i;
            s_d.act  = (load_cnt_i != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_nx_o  = s_d.act;
    assign dir_nx_o  = s_d.dir;
    assign prio_nx_o = s_d.prio;
    assign done_o    = s_q.done;
    assign err_o     = s_q.err;

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
    parameter int NCH    = 4,
    parameter int PRIO_W = 2,
    localparam int IDX_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]        cand_i,
    input  logic [NCH*PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]      last_i,
    output logic                  any_o,
    output logic [IDX_W-1:0]      idx_o
);

    logic [PRIO_W-1:0] best;
    logic              found;

    always_comb begin
        best = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best)) begin
                best = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
        any_o = |cand_i;
        idx_o = '0;
        found = 1'b0;
        // rotate the search so that the last winner is looked at last
        for (int k = 1; k <= NCH; k++) begin
            int j;
            j = (int'(last_i) + k) % NCH;
            if (!found && cand_i[j] && (prio_i[j*PRIO_W +: PRIO_W] == best)) begin
                found = 1'b1;
                idx_o = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int PRIO_W = 2,
    parameter int CNT_W  = 8,
    parameter int LEN_W  = 4,
    localparam int IDX_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_ch_i,
    input  logic [CNT_W-1:0]  cfg_cnt_i,
    input  logic              cfg_dir_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic [LEN_W-1:0]  burst_len_i,
    input  logic [NCH-1:0]    req_i,
    input  logic [NCH-1:0]    urgent_i,
    input  logic              bus_err_i,
    output logic [NCH-1:0]    grant_o,
    output logic              grant_dir_o,
    output logic [NCH-1:0]    done_irq_o,
    output logic [NCH-1:0]    err_irq_o
);

    typedef struct packed {
        logic [NCH-1:0]   grant;  // one-hot grant for the current cycle
        logic [IDX_W-1:0] own;    // owner of the running burst
        logic [IDX_W-1:0] last;   // round-robin reference
        logic [LEN_W-1:0] left;   // burst words still owed to the owner
        logic             gdir;   // direction of the most recent grant
        logic             was;    // a grant was present one cycle earlier
    } arb_t;

    arb_t s_d, s_q;

    logic [NCH-1:0]        act_nx;
    logic [NCH-1:0]        dir_nx;
    logic [NCH*PRIO_W-1:0] prio_nx;
    logic [NCH-1:0]        elig;
    logic [NCH-1:0]        urg;
    logic [NCH-1:0]        cand;
    logic                  win_any;
    logic [IDX_W-1:0]      win_idx;
    logic [LEN_W-1:0]      blen;
    logic                  keep;
    logic                  turn_block;
    arb_dec_e              dec;

    // per-channel transfer state
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_arb_chan #(
            .CNT_W  (CNT_W),
            .PRIO_W (PRIO_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (cfg_we_i && (cfg_ch_i == IDX_W'(i))),
            .load_cnt_i  (cfg_cnt_i),
            .load_dir_i  (cfg_dir_i),
            .load_prio_i (cfg_prio_i),
            .word_i      (s_q.grant[i]),
            .bus_err_i   (bus_err_i),
            .act_nx_o    (act_nx[i]),
            .dir_nx_o    (dir_nx[i]),
            .prio_nx_o   (prio_nx[i*PRIO_W +: PRIO_W]),
            .done_o      (done_irq_o[i]),
            .err_o       (err_irq_o[i])
        );
    end

    assign elig = act_nx & req_i;
    assign urg  = elig & urgent_i;
    assign cand = (|urg) ? urg : elig;
    assign blen = (burst_len_i == '0) ? LEN_W'(1) : burst_len_i;

    dma_arb_pick #(
        .NCH    (NCH),
        .PRIO_W (PRIO_W)
    ) u_pick (
        .cand_i (cand),
        .prio_i (prio_nx),
        .last_i (s_q.last),
        .any_o  (win_any),
        .idx_o  (win_idx)
    );

    always_comb begin
        s_d     = s_q;
        s_d.was = |s_q.grant;

        keep       = (|s_q.grant) && cand[s_q.own] && (s_q.left != '0);
        turn_block = ((|s_q.grant) || s_q.was) && (dir_nx[win_idx] != s_q.gdir);

        if (keep) begin
            dec = DEC_KEEP;
        end else if (!win_any) begin
            dec = DEC_IDLE;
        end else if (turn_block) begin
            dec = DEC_HOLD;
        end else begin
            dec = DEC_NEW;
        end

        unique case (dec)
            DEC_KEEP: begin
                s_d.left = s_q.left - LEN_W'(1);
            end
            DEC_NEW: begin
                s_d.grant          = '0;
                s_d.grant[win_idx] = 1'b1;
                s_d.own            = win_idx;
                s_d.last           = win_idx;
                s_d.left           = blen - LEN_W'(1);
                s_d.gdir           = dir_nx[win_idx];
            end
            default: begin
                s_d.grant = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.last <= IDX_W'(NCH - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_o     = s_q.grant;
    assign grant_dir_o = s_q.gdir;

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we_i,
    input logic           bus_err_i,
    input logic [NCH-1:0] grant_o,
    input logic           grant_dir_o,
    input logic [NCH-1:0] done_irq_o,
    input logic [NCH-1:0] err_irq_o
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R1

    AST_ADJ_SAME_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && $past(|grant_o)) |-> (grant_dir_o == $past(grant_dir_o))); // R5

    AST_GAP_SAME_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && $past(|grant_o, 2)) |-> (grant_dir_o == $past(grant_dir_o, 2))); // R5

    AST_DONE_FROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_irq_o) |-> ((done_irq_o & ~$past(grant_o)) == '0)); // R8

    AST_NO_REGRANT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we_i) |-> (((done_irq_o | err_irq_o) & grant_o) == '0)); // R8

    AST_ERR_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_irq_o) |-> ($past(bus_err_i) && (err_irq_o == $past(grant_o)))); // R9

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_irq_o & err_irq_o) == '0)); // R9

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we_i),
    .bus_err_i   (bus_err_i),
    .grant_o     (grant_o),
    .grant_dir_o (grant_dir_o),
    .done_irq_o  (done_irq_o),
    .err_irq_o   (err_irq_o)
);

// File: tb/dma_bus_arbiter_tb_top.sv
module dma_bus_arbiter_tb_top;

    localparam int NCH = 4, PRIO_W = 2, CNT_W = 8, LEN_W = 4, IDX_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              cfg_we_i = 1'b0;
    logic [IDX_W-1:0]  cfg_ch_i = '0;
    logic [CNT_W-1:0]  cfg_cnt_i = '0;
    logic              cfg_dir_i = 1'b0;
    logic [PRIO_W-1:0] cfg_prio_i = '0;
    logic [LEN_W-1:0]  burst_len_i = 4'd1;
    logic [NCH-1:0]    req_i = '0;
    logic [NCH-1:0]    urgent_i = '0;
    logic              bus_err_i = 1'b0;
    logic [NCH-1:0]    grant_o;
    logic              grant_dir_o;
    logic [NCH-1:0]    done_irq_o;
    logic [NCH-1:0]    err_irq_o;

    dma_bus_arbiter #(.NCH(NCH), .PRIO_W(PRIO_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i),
        .cfg_cnt_i(cfg_cnt_i), .cfg_dir_i(cfg_dir_i), .cfg_prio_i(cfg_prio_i),
        .burst_len_i(burst_len_i), .req_i(req_i), .urgent_i(urgent_i),
        .bus_err_i(bus_err_i), .grant_o(grant_o), .grant_dir_o(grant_dir_o),
        .done_irq_o(done_irq_o), .err_irq_o(err_irq_o)
    );

    int    errors = 0;
    int    checks = 0;
    bit    fin = 1'b0;
    string tag = "R1";

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt [NCH];
    int m_dir [NCH];
    int m_prio[NCH];
    bit m_act [NCH];
    bit m_done[NCH];
    bit m_err [NCH];
    int m_grant = -1;
    int m_gdir = 0;
    bit m_was = 0;
    int m_left = 0;
    int m_rr = NCH - 1;

    function automatic int mpick(bit c[NCH]);
        int best = -1;
        for (int i = 0; i < NCH; i++) if (c[i] && m_prio[i] > best) best = m_prio[i];
        for (int k = 1; k <= NCH; k++) begin
            int j = (m_rr + k) % NCH;
            if (c[j] && m_prio[j] == best) return j;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_cnt[i] = 0; m_dir[i] = 0; m_prio[i] = 0;
                m_act[i] = 0; m_done[i] = 0; m_err[i] = 0;
            end
            m_grant = -1; m_gdir = 0; m_was = 0; m_left = 0; m_rr = NCH - 1;
        end else begin
            bit c[NCH];
            bit anyu;
            int w, ng, blen;
            for (int i = 0; i < NCH; i++) begin m_done[i] = 0; m_err[i] = 0; end
            if (m_grant >= 0 && m_act[m_grant]) begin
                if (bus_err_i) begin
                    m_act[m_grant] = 0; m_cnt[m_grant] = 0; m_err[m_grant] = 1;
                end else begin
                    m_cnt[m_grant]--;
                    if (m_cnt[m_grant] == 0) begin m_act[m_grant] = 0; m_done[m_grant] = 1; end
                end
            end
            if (cfg_we_i) begin
                m_cnt[cfg_ch_i] = int'(cfg_cnt_i);
                m_dir[cfg_ch_i] = int'(cfg_dir_i);
                m_prio[cfg_ch_i] = int'(cfg_prio_i);
                m_act[cfg_ch_i] = (cfg_cnt_i != 0);
            end
            anyu = 0;
            for (int i = 0; i < NCH; i++) if (m_act[i] && req_i[i] && urgent_i[i]) anyu = 1;
            for (int i = 0; i < NCH; i++)
                c[i] = m_act[i] && req_i[i] && (!anyu || urgent_i[i]);
            blen = (burst_len_i == 0) ? 1 : int'(burst_len_i);
            ng = -1;
            if (m_grant >= 0 && c[m_grant] && m_left > 0) begin
                ng = m_grant; m_left--;
            end else begin
                w = mpick(c);
                if (w >= 0 && !((m_grant >= 0 || m_was) && m_dir[w] != m_gdir)) begin
                    ng = w; m_rr = w; m_left = blen - 1; m_gdir = m_dir[w];
                end
            end
            m_was = (m_grant >= 0);
            m_grant = ng;
        end
    end

    // ---------------- per-cycle comparison and history ----------------
    int             hist[$];
    logic [NCH-1:0] hdone[$];
    logic [NCH-1:0] herr[$];

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            logic [NCH-1:0] eg, ed, ee;
            int gi;
            eg = '0; ed = '0; ee = '0;
            if (m_grant >= 0) eg[m_grant] = 1'b1;
            for (int i = 0; i < NCH; i++) begin ed[i] = m_done[i]; ee[i] = m_err[i]; end
            chk(grant_o == eg, tag, "grant", int'(grant_o), int'(eg));
            if (m_grant >= 0) chk(grant_dir_o == m_gdir[0], "R5", "grant_dir", int'(grant_dir_o), m_gdir);
            chk(done_irq_o == ed, "R8", "done_irq", int'(done_irq_o), int'(ed));
            chk(err_irq_o == ee, "R9", "err_irq", int'(err_irq_o), int'(ee));
            gi = -1;
            for (int i = 0; i < NCH; i++) if (grant_o[i]) gi = i;
            hist.push_back(gi);
            hdone.push_back(done_irq_o);
            herr.push_back(err_irq_o);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic setup(int ch, int cnt, int dir, int pr);
        tick(1);
        cfg_we_i = 1'b1; cfg_ch_i = IDX_W'(ch); cfg_cnt_i = CNT_W'(cnt);
        cfg_dir_i = dir[0]; cfg_prio_i = PRIO_W'(pr);
        tick(1);
        cfg_we_i = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 400; k++) begin
            bit busy = (m_grant >= 0);
            for (int i = 0; i < NCH; i++) if (m_act[i]) busy = 1;
            if (!busy) break;
            tick(1);
        end
        req_i = '0; urgent_i = '0;
        tick(3);
    endtask

    task automatic clear_hist();
        hist.delete(); hdone.delete(); herr.delete();
    endtask

    function automatic int first_of(int v);
        foreach (hist[i]) if (hist[i] == v) return i;
        return -1;
    endfunction

    function automatic int last_of(int v);
        int r = -1;
        foreach (hist[i]) if (hist[i] == v) r = i;
        return r;
    endfunction

    function automatic int count_of(int v);
        int r = 0;
        foreach (hist[i]) if (hist[i] == v) r++;
        return r;
    endfunction

    function automatic int hat(int i);
        if (i < 0 || i >= hist.size()) return -9;
        return hist[i];
    endfunction

    // ---------------- scenarios ----------------
    initial begin
        int f, l, n, idle, seen;

        repeat (3) @(posedge clk);
        #1;
        chk(grant_o == '0, "R1", "grant in reset", int'(grant_o), 0);
        chk(done_irq_o == '0 && err_irq_o == '0, "R1", "irq in reset",
            int'(done_irq_o | err_irq_o), 0);
        @(negedge clk); rst_n = 1'b1;
        tick(2);
        chk(grant_o == '0, "R1", "grant after reset", int'(grant_o), 0);

        // same direction, two channels, burst 4
        tag = "R2";
        burst_len_i = 4'd4;
        setup(0, 6, 0, 1); setup(1, 6, 0, 1);
        clear_hist();
        req_i = 4'b0011;
        drain();
        f = first_of(0); l = (last_of(0) > last_of(1)) ? last_of(0) : last_of(1);
        idle = 0;
        for (int i = f; i <= l; i++) if (hat(i) < 0) idle++;
        chk(idle == 0, "R2", "idle cycles while streaming", idle, 0);
        chk(count_of(0) + count_of(1) == 12, "R2", "words granted", count_of(0) + count_of(1), 12);
        n = 0;
        for (int i = f; i < f + 4; i++) if (hat(i) == 0) n++;
        chk(n == 4, "R3", "first burst length of ch0", n, 4);
        chk(hat(f + 4) == 1, "R6", "round-robin handover to ch1", hat(f + 4), 1);
        l = last_of(0);
        chk(hdone[l + 1][0] == 1'b1, "R8", "ch0 done one cycle after last word", int'(hdone[l + 1][0]), 1);
        n = 0;
        foreach (hdone[i]) if (hdone[i][0]) n++;
        chk(n == 1, "R8", "ch0 done pulses", n, 1);

        // opposite directions: turnaround gap
        tag = "R5";
        setup(0, 4, 0, 1); setup(1, 4, 1, 1);
        clear_hist();
        req_i = 4'b0011;
        drain();
        f = first_of(0);
        chk(hat(f + 3) == 0 && hat(f + 4) == -1 && hat(f + 5) == -1, "R5", "two idle cycles after ch0 burst",
            hat(f + 5), -1);
        chk(hat(f + 6) == 1, "R5", "ch1 granted after gap", hat(f + 6), 1);

        // priority
        tag = "R4";
        burst_len_i = 4'd1;
        setup(2, 3, 0, 3); setup(3, 3, 0, 1);
        clear_hist();
        req_i = 4'b1100;
        drain();
        f = first_of(2);
        chk(f >= 0 && hat(f + 1) == 2 && hat(f + 2) == 2 && hat(f + 3) == 3, "R4",
            "high priority served first", hat(f + 3), 3);

        // round-robin among equals, burst length 0 acts as 1
        tag = "R6";
        burst_len_i = 4'd0;
        setup(0, 2, 0, 2); setup(1, 2, 0, 2); setup(2, 2, 0, 2);
        clear_hist();
        req_i = 4'b0111;
        drain();
        f = first_of(0);
        chk(hat(f) == 0 && hat(f + 1) == 1 && hat(f + 2) == 2 && hat(f + 3) == 0, "R6",
            "rotation order", hat(f + 1) * 10 + hat(f + 2), 12);
        chk(hat(f + 1) != 0, "R3", "zero burst length yields one word", hat(f + 1), 1);

        // urgent pre-emption of a long burst
        tag = "R7";
        burst_len_i = 4'd8;
        setup(3, 2, 0, 0); setup(0, 20, 0, 3);
        clear_hist();
        req_i = 4'b0001;
        tick(3);
        urgent_i = 4'b1000; req_i = 4'b1001;
        tick(1);
        chk(grant_o == 4'b1000, "R7", "urgent granted next cycle", int'(grant_o), 8);
        drain();
        f = first_of(0); l = first_of(3);
        chk(l > f && l < f + 8, "R7", "burst cut short", l - f, 3);
        chk(hat(l - 1) == 0, "R7", "pre-emption follows a ch0 word", hat(l - 1), 0);

        // bus error aborts a channel
        tag = "R9";
        burst_len_i = 4'd4;
        setup(1, 5, 0, 1);
        clear_hist();
        req_i = 4'b0010;
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            tick(1);
            bus_err_i = 1'b0;
            if (grant_o[1]) begin
                seen++;
                if (seen == 2) bus_err_i = 1'b1;
            end
        end
        bus_err_i = 1'b0;
        drain();
        chk(count_of(1) == 2, "R9", "words before abort", count_of(1), 2);
        n = 0; idle = 0;
        foreach (herr[i]) if (herr[i][1]) n++;
        foreach (hdone[i]) if (hdone[i][1]) idle++;
        chk(n == 1, "R9", "error pulses", n, 1);
        chk(idle == 0, "R9", "no completion after abort", idle, 0);

        // eligibility: zero count and low request
        tag = "R10";
        setup(2, 0, 0, 3); setup(3, 3, 0, 1);
        clear_hist();
        req_i = 4'b0100;
        tick(10);
        chk(count_of(2) == 0, "R10", "zero-count channel granted", count_of(2), 0);
        chk(count_of(3) == 0, "R10", "unrequested channel granted", count_of(3), 0);
        req_i = 4'b1100;
        drain();
        chk(count_of(3) == 3, "R10", "words after request", count_of(3), 3);

        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!fin) begin
            fin = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule